// File: doc/BRIEF.md
# Read-Only Serial Result Port for a Single-Shot Converter

This block is the digital front end that sits between a two-wire serial bus (I2C) and an abstract single-shot converter core. It runs the converter through a repeating life cycle: a power-up hold, a conversion window, and a sleep phase in which the last result is held unchanged. While it sleeps, a bus master can select the block by its fixed address with a read request and clock the 16-bit result out, most significant bit first, in two bytes.

A new conversion begins when a full 16-bit readout finishes, or when the master sends STOP after a read that the block acknowledged, whether or not any data bits were clocked. A repeated START does not begin a conversion, so the held value can be read more than once. While a conversion is running, the block refuses its own address with a NAK. The block never drives SDA high. It only pulls SDA low through an output enable. Both bus lines are synchronized to the system clock and filtered against short glitches.

Top module: `conv_rd_slave`

## Requirements
- R1: A START followed by address 0010100 (sent MSB first) and a direction bit of 1 is answered with ACK: SDA is pulled low for the whole ninth clock.
- R2: Any other address, or the right address with direction bit 0, is answered with NAK (SDA released on the ninth clock). The block then ignores the bus until the next START. No conversion starts, and the held result is left as it was.
- R3: A matching read address that arrives while a conversion is running gets a NAK.
- R4: After reset is released, the block waits exactly PWRUP_CYC clock cycles and then raises conv_start_o for a single cycle.
- R5: busy_o is high for exactly CONV_CYC cycles, starting in the cycle of conv_start_o. The held result is loaded from result_i only on a cycle inside that window where done_i is high, and it does not change outside the window.
- R6: After ACK, the result is output as bit 15 down to bit 0: bits 15..8 first, then a master acknowledge clock, then bits 7..0, then a master acknowledge clock. SDA changes only after SCL falling edges.
- R7: When the clock that carries bit 0 falls, exactly one conv_start_o pulse is issued. A later STOP does not issue another.
- R8: A STOP after an acknowledged read starts exactly one conversion, even when no data bit was clocked.
- R9: A repeated START that follows an acknowledged read starts no conversion. Reading again returns the same held value.
- R10: If the master NAKs the first data byte, SDA is released from the next clock on, and the following STOP starts a conversion.
- R11: An SDA or SCL pulse shorter than FILT_CYC clock cycles has no effect. In particular, a short SDA low pulse while SCL is high is not taken as a START.
- R12: SDA is released at all times except during the address ACK clock and the data bit clocks.

Output encoding: SDA low means the slave pulls the line, which corresponds to sda_oe_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| result_i | input | 16 | Parallel result from converter core |
| done_i | input | 1 | Result valid strobe from converter core |
| conv_start_o | output | 1 | One-cycle pulse that begins a conversion |
| busy_o | output | 1 | High during the conversion window |

## Verification
The assertions assume that the bus master keeps every SCL phase, and every SDA setup time before an SCL edge, longer than the filter delay plus a few cycles. They also assume that SDA and SCL never change in the same system-clock cycle, so that START, STOP and data edges can always be told apart after filtering. The bench master moves one line per quarter bit, with a quarter bit much longer than the filter latency, and changes SDA only while SCL is low, except on purpose for START, STOP and the single glitch stimulus. The converter model always raises done_i inside the conversion window and drives changing garbage on result_i at all other times, so the capture rule can be seen in the data that is read back.

// File: rtl/conv_rd_pkg.sv
package conv_rd_pkg;
  localparam int unsigned RES_W = 16;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_AACK,
    BUS_DATA,
    BUS_MACK,
    BUS_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    SEQ_PWRUP,
    SEQ_CONV,
    SEQ_SLEEP
  } seq_st_e;
endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int unsigned FILT_CYC = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic          lvl_q, prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      lvl_q  <= 1'b1;
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= lvl_q;
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        lvl_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;

  // filtered level only moves after the synchronized pin has disagreed with it
  assert_filter_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(sync_q[1] != lvl_q));
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_rd_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 125000,
  parameter int unsigned CONV_CYC  = 4150000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic [RES_W-1:0] hold_o
);
  localparam int unsigned MAXC = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  seq_st_e          st_q;
  logic [CW-1:0]    cnt_q;
  logic             start_q;
  logic [RES_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SEQ_PWRUP;
      cnt_q   <= '0;
      start_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (st_q)
        SEQ_PWRUP: begin
          if (cnt_q == CW'(PWRUP_CYC - 1)) begin
            st_q    <= SEQ_CONV;
            start_q <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_CONV: begin
          if (done_i) hold_q <= result_i;
          if (cnt_q == CW'(CONV_CYC - 1)) begin
            st_q  <= SEQ_SLEEP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_SLEEP: begin
          if (req_i) begin
            st_q    <= SEQ_CONV;
            start_q <= 1'b1;
            cnt_q   <= '0;
          end
        end
        default: st_q <= SEQ_PWRUP;
      endcase
    end
  end

  assign start_o = start_q;
  assign busy_o  = (st_q == SEQ_CONV);
  assign ready_o = (st_q == SEQ_SLEEP);
  assign hold_o  = hold_q;

  assert_start_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(hold_q));
  // the bus side only asks for a conversion while the converter sleeps
  assert_req_in_sleep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ready_o);
endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
  import conv_rd_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b0010100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_lvl_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ready_i,
  input  logic [RES_W-1:0] hold_i,
  output logic             sda_oe_o,
  output logic             conv_req_o
);
  bus_st_e    st_q;
  logic [3:0] cnt_q;
  logic [3:0] idx_q;
  logic [6:0] addr_q;
  logic       match_q, mack_q, armed_q, oe_q, req_q;
  logic [3:0] nidx;

  assign nidx = idx_q - 4'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      match_q <= 1'b0;
      mack_q  <= 1'b0;
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (start_i) begin
        st_q  <= BUS_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_i) begin
        st_q <= BUS_IDLE;
        oe_q <= 1'b0;
        if (armed_q) begin
          req_q   <= 1'b1;
          armed_q <= 1'b0;
        end
      end else begin
        unique case (st_q)
          BUS_ADDR: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              addr_q <= {addr_q[5:0], sda_lvl_i};
              cnt_q  <= cnt_q + 4'd1;
              if (cnt_q == 4'd7)
                match_q <= (addr_q == SLAVE_ADDR) && sda_lvl_i && ready_i;
            end
            if (scl_fall_i && cnt_q == 4'd8) begin
              if (match_q) begin
                st_q    <= BUS_AACK;
                oe_q    <= 1'b1;
                armed_q <= 1'b1;
              end else begin
                st_q <= BUS_SKIP;
              end
            end
          end
          BUS_AACK: begin
            if (scl_fall_i) begin
              st_q  <= BUS_DATA;
              idx_q <= 4'd15;
              cnt_q <= '0;
              oe_q  <= ~hold_i[15];
            end
          end
          BUS_DATA: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd7) begin
                st_q <= BUS_MACK;
                oe_q <= 1'b0;
                if (idx_q == 4'd0) begin
                  req_q   <= 1'b1;
                  armed_q <= 1'b0;
                end
              end else begin
                idx_q <= nidx;
                cnt_q <= cnt_q + 4'd1;
                oe_q  <= ~hold_i[nidx];
              end
            end
          end
          BUS_MACK: begin
            if (scl_rise_i) mack_q <= ~sda_lvl_i;
            if (scl_fall_i) begin
              if (mack_q && idx_q != 4'd0) begin
                st_q  <= BUS_DATA;
                idx_q <= nidx;
                cnt_q <= '0;
                oe_q  <= ~hold_i[nidx];
              end else begin
                st_q <= BUS_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign conv_req_o = req_q;

  assert_ack_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BUS_AACK) |-> ready_i);
  assert_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (st_q == BUS_AACK || st_q == BUS_DATA));
  assert_oe_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> $past(scl_fall_i || start_i || stop_i));
  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
endmodule

// File: rtl/conv_rd_slave.sv
module conv_rd_slave
  import conv_rd_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR = 7'b0010100,
  parameter int unsigned FILT_CYC   = 13,
  parameter int unsigned PWRUP_CYC  = 125000,
  parameter int unsigned CONV_CYC   = 4150000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [RES_W-1:0] result_i,
  input  logic             done_i,
  output logic             conv_start_o,
  output logic             busy_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_p, stop_p, ready, req;
  logic [RES_W-1:0] hold;

  i2c_deglitch #(.FILT_CYC(FILT_CYC)) u_scl_flt (
    .clk_i, .rst_ni, .pin_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_deglitch #(.FILT_CYC(FILT_CYC)) u_sda_flt (
    .clk_i, .rst_ni, .pin_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_p = scl_lvl & sda_fall;
  assign stop_p  = scl_lvl & sda_rise;

  i2c_rd_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_engine (
    .clk_i, .rst_ni,
    .sda_lvl_i(sda_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_p), .stop_i(stop_p),
    .ready_i(ready), .hold_i(hold),
    .sda_oe_o, .conv_req_o(req)
  );

  conv_seq #(.PWRUP_CYC(PWRUP_CYC), .CONV_CYC(CONV_CYC)) u_seq (
    .clk_i, .rst_ni, .req_i(req), .done_i, .result_i,
    .start_o(conv_start_o), .busy_o, .ready_o(ready), .hold_o(hold)
  );
endmodule

// File: tb/conv_rd_slave_bench.sv
`timescale 1ns/1ps
module conv_rd_slave_bench;
  localparam int PWRUP = 200;
  localparam int CONV  = 3000;
  localparam int DONE_AT = 2000;
  localparam int Q = 25;
  localparam logic [6:0] ADDR = 7'b0010100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, done, conv_start, busy;
  logic [15:0] result;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  int n_starts = 0, n_conv = 0, core_cnt = 0, busy_run = 0, last_busy = 0, cyc = 0;

  always #2 clk = ~clk;

  conv_rd_slave #(.FILT_CYC(13), .PWRUP_CYC(PWRUP), .CONV_CYC(CONV)) u_conv_rd_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .result_i(result), .done_i(done), .conv_start_o(conv_start), .busy_o(busy)
  );

  function automatic logic [15:0] val(int k);
    if (k == 0) return 16'h8000;
    if (k == 1) return 16'hFFFF;
    if (k == 2) return 16'h0000;
    return 16'(k * 40503) ^ 16'h5A5A;
  endfunction

  // converter model and port monitors
  always @(negedge clk) begin
    cyc++;
    done   <= 1'b0;
    result <= 16'hDEAD ^ 16'(cyc * 7);
    if (rst_n) begin
      if (busy) busy_run++;
      else if (busy_run != 0) begin last_busy = busy_run; busy_run = 0; end
      if (conv_start) begin
        n_starts++;
        core_cnt = DONE_AT;
      end else if (core_cnt > 0) begin
        core_cnt--;
        if (core_cnt == 0) begin
          done   <= 1'b1;
          result <= val(n_conv);
          n_conv++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask
  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic rd_addr(input logic [6:0] a, input logic rw, output logic ack);
    logic b;
    bus_start();
    for (int i = 6; i >= 0; i--) send_bit(a[i]);
    send_bit(rw);
    recv_bit(b);
    ack = ~b;
  endtask
  task automatic rd_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~mack);
  endtask
  task automatic wait_sleep();
    @(negedge clk);
    while (busy || conv_start) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack, b;
    logic [7:0] hi, lo;
    int n;
    repeat (5) @(negedge clk);
    chk(!sda_oe && !busy && !conv_start, "R4 reset outputs", {sda_oe, busy, conv_start}, 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!conv_start && n < 1000);
    chk(n == PWRUP, "R4 powerup delay", n, PWRUP);
    chk(busy, "R5 busy with start", busy, 1);

    // R3: own address during conversion
    rd_addr(ADDR, 1'b1, ack);
    chk(!ack, "R3 nak while busy", ack, 0);
    bus_stop();
    chk(n_starts == 1, "R3 no start after nak", n_starts, 1);
    wait_sleep();
    chk(last_busy == CONV, "R5 busy window", last_busy, CONV);

    // R2: write direction and wrong address
    rd_addr(ADDR, 1'b0, ack);
    chk(!ack, "R2 write nak", ack, 0);
    bus_stop();
    rd_addr(ADDR ^ 7'h01, 1'b1, ack);
    chk(!ack, "R2 address mismatch nak", ack, 0);
    bus_stop();
    chk(n_starts == 1, "R2 no conversion", n_starts, 1);

    // R11: short SDA low while SCL high, then an address without START
    sda_m = 1'b0; repeat (8) @(negedge clk); sda_m = 1'b1; wq();
    scl_m = 1'b0; wq();
    for (int i = 6; i >= 0; i--) send_bit(ADDR[i]);
    send_bit(1'b1);
    recv_bit(b);
    chk(b, "R11 glitch not a start", b, 1);
    bus_stop();
    chk(n_starts == 1, "R11 no conversion", n_starts, 1);

    // R1 R6 R7: full readout of first result (also proves R2/R5 hold)
    rd_addr(ADDR, 1'b1, ack);
    chk(ack, "R1 ack", ack, 1);
    rd_byte(1'b1, hi);
    chk(n_starts == 1, "R7 no start mid read", n_starts, 1);
    rd_byte(1'b0, lo);
    chk({hi, lo} == val(0), "R6 data first", {hi, lo}, val(0));
    chk(n_starts == 2, "R7 start after bit 0", n_starts, 2);
    bus_stop();
    chk(n_starts == 2, "R7 no second start on stop", n_starts, 2);
    wait_sleep();

    // R9 R10: first byte, master NAK, repeated START, full reread
    rd_addr(ADDR, 1'b1, ack);
    chk(ack, "R1 ack second", ack, 1);
    rd_byte(1'b0, hi);
    chk(hi == val(1) >> 8, "R6 high byte", hi, val(1) >> 8);
    rd_addr(ADDR, 1'b1, ack);
    chk(ack && n_starts == 2, "R9 no start on repeated start", n_starts, 2);
    rd_byte(1'b1, hi);
    rd_byte(1'b0, lo);
    chk({hi, lo} == val(1), "R9 reread same value", {hi, lo}, val(1));
    bus_stop();
    chk(n_starts == 3, "R7 start after reread", n_starts, 3);
    wait_sleep();

    rd_addr(ADDR, 1'b1, ack);
    rd_byte(1'b1, hi);
    rd_byte(1'b0, lo);
    chk(ack && {hi, lo} == val(2), "R6 data zero", {hi, lo}, val(2));
    bus_stop();
    wait_sleep();

    // R8: acknowledged read then STOP without data
    rd_addr(ADDR, 1'b1, ack);
    chk(ack, "R1 ack before discard", ack, 1);
    bus_stop();
    chk(n_starts == 5, "R8 stop starts conversion", n_starts, 5);
    wait_sleep();

    // R10 R12: NAK first byte, bus released afterwards
    rd_addr(ADDR, 1'b1, ack);
    rd_byte(1'b0, hi);
    chk(hi == val(4) >> 8, "R10 high byte", hi, val(4) >> 8);
    recv_bit(b);
    chk(b, "R12 released after master nak", b, 1);
    chk(n_starts == 5, "R10 no start before stop", n_starts, 5);
    bus_stop();
    chk(n_starts == 6, "R10 stop starts conversion", n_starts, 6);
    wait_sleep();

    rd_addr(ADDR, 1'b1, ack);
    rd_byte(1'b1, hi);
    rd_byte(1'b0, lo);
    chk(ack && {hi, lo} == val(5), "R6 data after discard", {hi, lo}, val(5));
    bus_stop();
    chk(!sda_oe, "R12 idle released", sda_oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule